// File: doc/BRIEF.md
# Oversampled I2C target receiver/transmitter

This block is an I2C target (slave) that runs entirely on a fast system clock. SCL is never used to clock any flop. Both bus lines pass through a synchroniser and a run-length glitch filter, and bus events are found by comparing successive filtered samples. The block watches for START and STOP. It collects a 7-bit address and a direction bit, and answers only its own address. It then either hands each received byte to the host logic or transmits bytes that the host logic supplies.

SDA is open-drain. The block only asks for the line to be pulled low, through `sda_oe_o`, and otherwise leaves it released. Incoming SDA is taken only at a filtered SCL rising edge. The block's own SDA output moves only after a filtered SCL falling edge. This keeps sampling apart from driving, so a peer that changes SDA with zero hold time after SCL falls is handled correctly. Clock stretching, 10-bit addresses and multi-master arbitration are not part of the block.

Top module: `i2c_ovs_target`

## Requirements
- R1: A filtered line takes a new level only after FILT_LEN (default 3) consecutive synchronised samples of that level. A pulse shorter than that, on SCL or on SDA, has no effect on the transfer.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in any state, including a repeated START or one in the middle of a byte, restarts address reception.
- R3: After a START the first 8 bits, MSB first, hold a 7-bit address and then the direction bit, where 1 means read. If the address equals `dev_addr_i`, the block pulls SDA low for the whole ninth SCL period.
- R4: If the address does not match, `sda_oe_o` stays 0 and `rx_valid_o` stays 0 until the next START. The master sees a NACK (SDA high) in the ninth period.
- R5: In a write, each data byte (MSB first) appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse after the falling SCL edge of its eighth bit. The block then pulls SDA low for the ninth period.
- R6: In a read, the block takes `tx_data_i` in the cycle where `tx_load_o` pulses for one cycle, and sends it MSB first. Each bit is put on SDA only after a filtered SCL falling edge. After the eighth bit the block releases SDA for the master's acknowledge.
- R7: In a read, if the master answers the ninth bit with a NACK (SDA high), the transfer ends. SDA then stays released, even if more clocks follow, until the next START.
- R8: A STOP in any state returns the block to idle. Clocks that follow without a START are ignored, even when their data matches the address.
- R9: SDA is sampled only at the filtered SCL rising edge. Data changing at the very moment SCL falls (zero hold time) is received correctly.
- R10: `sda_oe_o` = 1 means pull SDA low, and 0 means release it. Out of reset `sda_oe_o`, `rx_valid_o` and `tx_load_o` are all 0.
- R11: Transfers are correct at 400 kHz and at 100 kHz SCL with a 125 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| dev_addr_i | input | 7 | Address this target answers to |
| tx_data_i | input | 8 | Next byte to send in a read |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| rx_data_o | output | 8 | Last byte received in a write |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| tx_load_o | output | 1 | One-cycle strobe: `tx_data_i` was taken |

## Verification
A pad edge reaches the engine after the synchroniser stages, then FILT_LEN filter samples, then one edge-detect register: 2 + 3 + 1 cycles at the defaults. Any SDA drive change or data strobe therefore follows the causing SCL edge by about seven clock cycles. The bench holds each quarter of a bus bit for 78 cycles (400 kHz) or 312 cycles (100 kHz), so every response has settled well before the next phase. The bench reads SDA in the middle of the SCL-high phase. It catches the one-cycle `rx_valid_o` and `tx_load_o` strobes with monitors on the falling clock edge, and each scenario compares the counts before and after it runs.

// File: rtl/i2c_ovs_pkg.sv
package i2c_ovs_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } ovs_state_t;

endpackage

// File: rtl/i2c_ovs_deglitch.sv
module i2c_ovs_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);

  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   lvl_q, lvl_d;

  // synchroniser chain, released bus level (1) out of reset
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[g] <= 1'b1;
      end else if (g == 0) begin
        sync_q[g] <= pin_i;
      end else begin
        sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
      end
    end
  end

  assign samp = sync_q[SYNC_STAGES-1];

  // run-length filter: accept a new level after FILT_LEN equal samples
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (samp == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      lvl_d = samp;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = lvl_q;

  // R1: a filtered change always agrees with the newest synchronised sample
  a_r1_change_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(samp) == lvl_q));

endmodule

// File: rtl/i2c_ovs_cond.sv
module i2c_ovs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // an SDA edge counts as a condition only while SCL was and still is high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_ovs_engine.sv
module i2c_ovs_engine
  import i2c_ovs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_load_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  ovs_state_t        state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shr_q, shr_d;
  logic              rw_q, rw_d;
  logic              acked_q, acked_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic              rxv_q, rxv_d;
  logic              ld_q, ld_d;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shr_d   = shr_q;
    rw_d    = rw_q;
    acked_d = acked_q;
    oe_d    = oe_q;
    rxd_d   = rxd_q;
    rxv_d   = 1'b0;
    ld_d    = 1'b0;

    if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      bcnt_d  = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;

        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bcnt_q != FULL) begin
            shr_d  = {shr_q[BYTE_W-2:0], sda_i};
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall_i && bcnt_q == FULL) begin
            if (state_q == ST_WR) begin
              rxd_d   = shr_q;
              rxv_d   = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end else if (shr_q[BYTE_W-1:1] == dev_addr_i) begin
              rw_d    = shr_q[0];
              oe_d    = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bcnt_d = '0;
            if (rw_q) begin
              shr_d   = tx_data_i;
              oe_d    = ~tx_data_i[BYTE_W-1];
              ld_d    = 1'b1;
              state_d = ST_RD;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WR;
            end
          end
        end

        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            bcnt_d  = '0;
            state_d = ST_WR;
          end
        end

        ST_RD: begin
          if (scl_rise_i && bcnt_q != FULL) begin
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall_i && bcnt_q != '0) begin
            if (bcnt_q == FULL) begin
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              shr_d = {shr_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~shr_q[BYTE_W-2];
            end
          end
        end

        ST_RD_ACK: begin
          if (scl_rise_i) begin
            acked_d = ~sda_i;
          end else if (scl_fall_i) begin
            if (acked_q) begin
              bcnt_d  = '0;
              shr_d   = tx_data_i;
              oe_d    = ~tx_data_i[BYTE_W-1];
              ld_d    = 1'b1;
              state_d = ST_RD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end

        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shr_q   <= '0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
      rxd_q   <= '0;
      rxv_q   <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shr_q   <= shr_d;
      rw_q    <= rw_d;
      acked_q <= acked_d;
      oe_q    <= oe_d;
      rxd_q   <= rxd_d;
      rxv_q   <= rxv_d;
      ld_q    <= ld_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_data_o  = rxd_q;
  assign rx_valid_o = rxv_q;
  assign tx_load_o  = ld_q;

  // R2: a START (without STOP) always reopens address reception
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (state_q == ST_ADDR && bcnt_q == '0));

  // R6 and R9: SDA is only pulled low after a filtered SCL fall
  a_r6_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  // R6: SDA is only released after an SCL fall or a bus condition
  a_r6_release_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));

  // R4 and R7: while idle, SDA is released
  a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R5: the receive strobe lasts exactly one cycle
  a_r5_rx_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R6: the load strobe lasts exactly one cycle and coincides with driving the first bit
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o);

endmodule

// File: rtl/i2c_ovs_target.sv
module i2c_ovs_target
  import i2c_ovs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_load_o
);

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_ovs_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (scl_i),
    .level_o (scl_f)
  );

  i2c_ovs_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (sda_i),
    .level_o (sda_f)
  );

  i2c_ovs_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_ovs_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .sda_i      (sda_f),
    .dev_addr_i (dev_addr_i),
    .tx_data_i  (tx_data_i),
    .sda_oe_o   (sda_oe_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .tx_load_o  (tx_load_o)
  );

  // R2: a bus condition and an SCL edge never arrive in the same cycle
  a_r2_cond_not_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |-> !(scl_rise || scl_fall));

endmodule

// File: tb/i2c_ovs_target_bench.sv
module i2c_ovs_target_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       m_scl, m_sda;
  logic [6:0] dev_addr;
  logic [7:0] tx_data;
  logic       sda_oe, rx_valid, tx_load;
  logic [7:0] rx_data;
  wire        sda_bus = m_sda & ~sda_oe;

  int tests = 0, fails = 0;
  int q = 78;
  int rx_cnt = 0, oe_cnt = 0, ld_cnt = 0;
  logic [7:0] rx_log [16];

  i2c_ovs_target u_i2c_ovs_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .dev_addr_i (dev_addr),
    .tx_data_i  (tx_data),
    .sda_oe_o   (sda_oe),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .tx_load_o  (tx_load)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37) ^ 8'h3C);
  endfunction

  assign tx_data = pat(ld_cnt);

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (rx_cnt < 16) rx_log[rx_cnt] = rx_data;
        rx_cnt++;
      end
      if (sda_oe) oe_cnt++;
      if (tx_load) ld_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(q);
    m_scl = 1'b1; wq(q);
    m_sda = 1'b0; wq(q);
    m_scl = 1'b0; wq(q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(q);
    m_scl = 1'b1; wq(q);
    m_sda = 1'b1; wq(q);
  endtask

  task automatic wbit(input bit b);
    m_sda = b;    wq(q);
    m_scl = 1'b1; wq(2 * q);
    m_scl = 1'b0; wq(q);
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; wq(q);
    m_scl = 1'b1; wq(q);
    b = sda_bus;  wq(q);
    m_scl = 1'b0; wq(q);
  endtask

  // mode 0 normal, 1 zero hold time, 2 with short glitches on both lines
  task automatic wbyte(input logic [7:0] d, input int mode, output bit ack);
    if (mode == 1) m_sda = d[7];
    for (int i = 7; i >= 0; i--) begin
      if (mode != 1) m_sda = d[i];
      wq(q);
      m_scl = 1'b1;
      if (mode == 2) begin
        wq(q); m_sda = ~m_sda; wq(2); m_sda = ~m_sda; wq(q - 2);
      end else begin
        wq(2 * q);
      end
      m_scl = 1'b0;
      if (mode == 1) m_sda = (i > 0) ? d[i-1] : 1'b1;
      if (mode == 2) begin
        wq(q / 2); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(q - q / 2 - 2);
      end else begin
        wq(q);
      end
    end
    rbit(ack);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      rbit(b);
      d[i] = b;
    end
    wbit(nack);
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(rx_valid == 1'b0, "R10 reset rx_valid", rx_valid, 0);
    chk(tx_load == 1'b0, "R10 reset tx_load", tx_load, 0);
  endtask

  task automatic t_write;
    bit a; int base = rx_cnt;
    bus_start;
    wbyte({dev_addr, 1'b0}, 0, a); chk(a == 0, "R3 address ack", a, 0);
    wbyte(8'h3C, 0, a);            chk(a == 0, "R5 data ack 1", a, 0);
    wbyte(8'hC3, 0, a);            chk(a == 0, "R5 data ack 2", a, 0);
    bus_stop;
    chk(rx_cnt - base == 2, "R5 byte count", rx_cnt - base, 2);
    chk(rx_log[base] == 8'h3C, "R5 byte 1", rx_log[base], 8'h3C);
    chk(rx_log[base+1] == 8'hC3, "R5 byte 2", rx_log[base+1], 8'hC3);
  endtask

  task automatic t_mismatch;
    bit a; int rb = rx_cnt; int ob = oe_cnt;
    bus_start;
    wbyte({dev_addr ^ 7'h01, 1'b0}, 0, a); chk(a == 1, "R4 foreign address nack", a, 1);
    wbyte(8'h00, 0, a);                    chk(a == 1, "R4 data after mismatch nack", a, 1);
    bus_stop;
    chk(rx_cnt == rb, "R4 no data out", rx_cnt - rb, 0);
    chk(oe_cnt == ob, "R4 sda never pulled", oe_cnt - ob, 0);
  endtask

  task automatic t_read;
    bit a; logic [7:0] d; int lb = ld_cnt; int ob;
    bus_start;
    wbyte({dev_addr, 1'b1}, 0, a); chk(a == 0, "R3 read address ack", a, 0);
    rbyte(1'b0, d); chk(d == pat(lb), "R6 read byte 1", d, pat(lb));
    rbyte(1'b1, d); chk(d == pat(lb + 1), "R6 read byte 2", d, pat(lb + 1));
    chk(ld_cnt - lb == 2, "R6 load strobes", ld_cnt - lb, 2);
    ob = oe_cnt;
    rbyte(1'b1, d);
    chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    chk(oe_cnt == ob, "R7 no drive after nack", oe_cnt - ob, 0);
    bus_stop;
  endtask

  task automatic t_restart;
    bit a; logic [7:0] d; int rb = rx_cnt; int lb;
    bus_start;
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_start;
    wbyte({dev_addr, 1'b0}, 0, a); chk(a == 0, "R2 start mid byte restarts", a, 0);
    wbyte(8'h55, 0, a);
    bus_start;
    lb = ld_cnt;
    wbyte({dev_addr, 1'b1}, 0, a); chk(a == 0, "R2 repeated start read ack", a, 0);
    rbyte(1'b1, d); chk(d == pat(lb), "R2 read after repeated start", d, pat(lb));
    bus_stop;
    chk(rx_cnt - rb == 1 && rx_log[rb] == 8'h55, "R2 write before repeated start", rx_log[rb], 8'h55);
  endtask

  task automatic t_stop_mid;
    bit a; int rb = rx_cnt;
    bus_start;
    wbyte({dev_addr, 1'b0}, 0, a);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_stop;
    wq(q);
    m_scl = 1'b0; wq(q);
    wbyte({dev_addr, 1'b0}, 0, a);
    chk(a == 1, "R8 no ack without start", a, 1);
    bus_stop;
    chk(rx_cnt == rb, "R8 no data after stop", rx_cnt - rb, 0);
  endtask

  task automatic t_zero_hold;
    bit a; int rb = rx_cnt;
    bus_start;
    wbyte({dev_addr, 1'b0}, 1, a); chk(a == 0, "R9 zero hold address ack", a, 0);
    wbyte(8'hA6, 1, a);
    bus_stop;
    chk(rx_cnt - rb == 1 && rx_log[rb] == 8'hA6, "R9 zero hold data", rx_log[rb], 8'hA6);
  endtask

  task automatic t_glitch;
    bit a; int rb = rx_cnt;
    bus_start;
    wbyte({dev_addr, 1'b0}, 2, a); chk(a == 0, "R1 glitched address ack", a, 0);
    wbyte(8'h69, 2, a);
    bus_stop;
    chk(rx_cnt - rb == 1, "R1 glitch count", rx_cnt - rb, 1);
    chk(rx_log[rb] == 8'h69, "R1 glitched data", rx_log[rb], 8'h69);
  endtask

  task automatic t_slow;
    bit a; logic [7:0] d; int rb = rx_cnt; int lb;
    q = 312;
    bus_start;
    wbyte({dev_addr, 1'b0}, 0, a); chk(a == 0, "R11 100k address ack", a, 0);
    wbyte(8'h96, 0, a);
    bus_start;
    lb = ld_cnt;
    wbyte({dev_addr, 1'b1}, 0, a);
    rbyte(1'b1, d); chk(d == pat(lb), "R11 100k read", d, pat(lb));
    bus_stop;
    chk(rx_log[rb] == 8'h96, "R11 100k write", rx_log[rb], 8'h96);
    q = 78;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    dev_addr = 7'h5A;
    wq(5);
    t_reset;
    rst_n = 1'b1;
    wq(20);
    t_write;
    t_mismatch;
    t_read;
    t_restart;
    t_stop_mid;
    t_zero_hold;
    t_glitch;
    t_slow;
    wq(20);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule